// File: doc/BRIEF.md
# Cubic Edge-Sharpening Pixel Pipeline

This block sharpens one pixel per clock. It takes an 8-bit centre sample and the four samples above, below, left and right of it. From these it forms a discrete Laplacian, the centre counted four times less the sum of the four neighbours. It then raises that value to the third power. Small ripples stay near zero while real edges become large.

The cubed term is scaled down by an arithmetic right shift and clamped to plus or minus 255. It is then added to the centre sample, which is treated as unsigned. The sum is saturated into the 0..255 output range. A later stage of a display scaler can feed the block a continuous stream of neighbourhoods. Each stage is separated by registers, and a valid flag follows the data with a fixed latency of five clock edges. The block has no control states. Data moves forward on every edge, and the flag only marks which results are meaningful.

Top module: `sr_sharpen_pipe`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` and `out_pix` are both 0 after that edge.
- R2: `out_valid` equals the `in_valid` value captured five rising edges earlier. The input set captured at edge k appears on `out_pix` after edge k+4, counting edge k as the first of five.
- R3: The high-pass term is 4·ctr − up − dn − lf − rt. A flat neighbourhood (all five equal) yields `out_pix` equal to the centre.
- R4: The high-pass term is cubed with its sign kept. A positive term never lowers the output below the centre, and a negative term never raises it.
- R5: The cubed term is compressed by an arithmetic right shift of SHIFT bits (default 16), rounding toward minus infinity. A term of −1 lowers the output by 1, while a term of +1 leaves the centre unchanged.
- R6: The compressed term is clamped to the range −255..+255.
- R7: The centre is zero-extended before the addition, so a centre of 255 is treated as +255 and not as a negative value.
- R8: The final sum is saturated. A sum below 0 gives 0, a sum above 255 gives 255, and any other sum passes through unchanged.
- R9: A new neighbourhood can be accepted on every clock. Back-to-back inputs each produce their own result in order, with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current neighbourhood as meaningful |
| ctr | input | PIX_W | Centre sample |
| up | input | PIX_W | Sample above the centre |
| dn | input | PIX_W | Sample below the centre |
| lf | input | PIX_W | Sample left of the centre |
| rt | input | PIX_W | Sample right of the centre |
| out_valid | output | 1 | Valid flag, delayed five edges |
| out_pix | output | PIX_W | Sharpened pixel |

## Verification
Several properties are checked on every cycle. The stage assertions check that a flat input gives a zero high-pass term and that the cube keeps the sign of its input. They also check that the shift-and-clamp result keeps the sign of the cube and saturates above 256·2^SHIFT. Further assertions check that the added result never falls below the clamped term and that the final limiter maps out-of-range sums to the rails. At the top level, the five-edge valid alignment is checked once five edges have passed since reset. Exact pixel values for specific neighbourhoods, the rounding of small negative terms, and ordering across an unbroken stream can only be shown by the bench scenarios, which compare against a behavioural model on each clock.

// File: rtl/sr_pkg.sv
package sr_pkg;
    localparam int PIX_W_DEF = 8;
    localparam int SHIFT_DEF = 16;
    localparam int LATENCY   = 5;

    function automatic int edge_width(input int pix_w);
        return pix_w + 3;
    endfunction

    function automatic int cube_width(input int pix_w);
        return 3 * (pix_w + 2) + 1;
    endfunction
endpackage

// File: rtl/sr_edge_term.sv
module sr_edge_term #(
    parameter int PIX_W  = 8,
    parameter int EDGE_W = PIX_W + 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PIX_W-1:0]         ctr,
    input  logic [PIX_W-1:0]         up,
    input  logic [PIX_W-1:0]         dn,
    input  logic [PIX_W-1:0]         lf,
    input  logic [PIX_W-1:0]         rt,
    output logic signed [EDGE_W-1:0] edge_q
);
    localparam int AW = EDGE_W + 1;

    logic signed [AW-1:0] pos_w;
    logic signed [AW-1:0] neg_w;
    logic signed [AW-1:0] diff_w;

    always_comb begin
        pos_w  = AW'({ctr, 2'b00});
        neg_w  = AW'(up) + AW'(dn) + AW'(lf) + AW'(rt);
        diff_w = pos_w - neg_w;
    end

    always_ff @(posedge clk) begin
        if (rst) edge_q <= '0;
        else     edge_q <= diff_w[EDGE_W-1:0];
    end

    p_flat_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (up == ctr && dn == ctr && lf == ctr && rt == ctr) |=> (edge_q == 0));
endmodule

// File: rtl/sr_cube.sv
module sr_cube #(
    parameter int EDGE_W = 11,
    parameter int CUBE_W = 31
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [EDGE_W-1:0] edge_in,
    output logic signed [CUBE_W-1:0] cube_q
);
    logic signed [CUBE_W-1:0] ext_w;
    logic signed [CUBE_W-1:0] cube_w;

    always_comb begin
        ext_w  = CUBE_W'(edge_in);
        cube_w = ext_w * ext_w * ext_w;
    end

    always_ff @(posedge clk) begin
        if (rst) cube_q <= '0;
        else     cube_q <= cube_w;
    end

    p_cube_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_in < 0) |=> (cube_q < 0));
    p_cube_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_in > 0) |=> (cube_q > 0));
    p_cube_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (edge_in == 0) |=> (cube_q == 0));
endmodule

// File: rtl/sr_compress.sv
module sr_compress #(
    parameter int PIX_W  = 8,
    parameter int CUBE_W = 31,
    parameter int SHIFT  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [CUBE_W-1:0] cube_in,
    output logic signed [PIX_W:0]    lim_q
);
    localparam int LIM_MAX = (1 << PIX_W) - 1;
    localparam logic signed [CUBE_W-1:0] HI = CUBE_W'(LIM_MAX);
    localparam logic signed [CUBE_W-1:0] LO = -HI;
    localparam logic signed [CUBE_W-1:0] SAT_IN = CUBE_W'(longint'(LIM_MAX + 1) << SHIFT);

    logic signed [CUBE_W-1:0] shr_w;
    logic signed [CUBE_W-1:0] clip_w;

    always_comb begin
        shr_w = cube_in >>> SHIFT;
        if (shr_w > HI)      clip_w = HI;
        else if (shr_w < LO) clip_w = LO;
        else                 clip_w = shr_w;
    end

    always_ff @(posedge clk) begin
        if (rst) lim_q <= '0;
        else     lim_q <= clip_w[PIX_W:0];
    end

    p_lim_neg_r5: assert property (@(posedge clk) disable iff (rst)
        (cube_in < 0) |=> (lim_q < 0));
    p_lim_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
        (cube_in >= 0) |=> (lim_q >= 0));
    p_lim_top_r6: assert property (@(posedge clk) disable iff (rst)
        (cube_in >= SAT_IN) |=> (lim_q == LIM_MAX));
    p_lim_bottom_r6: assert property (@(posedge clk) disable iff (rst)
        (cube_in <= -SAT_IN) |=> (lim_q == -LIM_MAX));
endmodule

// File: rtl/sr_merge.sv
module sr_merge #(
    parameter int PIX_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [PIX_W:0] lim_in,
    input  logic [PIX_W-1:0]      cen_in,
    output logic [PIX_W-1:0]      pix_q
);
    localparam int SUM_W   = PIX_W + 2;
    localparam int PIX_MAX = (1 << PIX_W) - 1;

    logic signed [SUM_W-1:0] sum_w;
    logic signed [SUM_W-1:0] sum_q;
    logic [PIX_W-1:0]        lim_out_w;

    always_comb begin
        sum_w = SUM_W'(lim_in) + $signed({2'b00, cen_in});
    end

    always_comb begin
        if (sum_q < 0)             lim_out_w = '0;
        else if (sum_q > PIX_MAX)  lim_out_w = PIX_W'(PIX_MAX);
        else                       lim_out_w = sum_q[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            pix_q <= '0;
        end else begin
            sum_q <= sum_w;
            pix_q <= lim_out_w;
        end
    end

    p_zext_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_q >= $past(lim_in)));
    p_sat_low_r8: assert property (@(posedge clk) disable iff (rst)
        (sum_q < 0) |=> (pix_q == 0));
    p_sat_high_r8: assert property (@(posedge clk) disable iff (rst)
        (sum_q > PIX_MAX) |=> (pix_q == PIX_MAX));
endmodule

// File: rtl/sr_sharpen_pipe.sv
module sr_sharpen_pipe
    import sr_pkg::*;
#(
    parameter int PIX_W = PIX_W_DEF,
    parameter int SHIFT = SHIFT_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] ctr,
    input  logic [PIX_W-1:0] up,
    input  logic [PIX_W-1:0] dn,
    input  logic [PIX_W-1:0] lf,
    input  logic [PIX_W-1:0] rt,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix
);
    localparam int EDGE_W  = edge_width(PIX_W);
    localparam int CUBE_W  = cube_width(PIX_W);
    localparam int CEN_DLY = 3;

    logic signed [EDGE_W-1:0] edge_s1;
    logic signed [CUBE_W-1:0] cube_s2;
    logic signed [PIX_W:0]    lim_s3;
    logic [PIX_W-1:0]         cen_pipe [CEN_DLY];
    logic [LATENCY-1:0]       vld_pipe;
    logic [2:0]               warm_q;

    sr_edge_term #(.PIX_W(PIX_W), .EDGE_W(EDGE_W)) u_edge (
        .clk(clk), .rst(rst), .ctr(ctr), .up(up), .dn(dn), .lf(lf), .rt(rt),
        .edge_q(edge_s1)
    );

    sr_cube #(.EDGE_W(EDGE_W), .CUBE_W(CUBE_W)) u_cube (
        .clk(clk), .rst(rst), .edge_in(edge_s1), .cube_q(cube_s2)
    );

    sr_compress #(.PIX_W(PIX_W), .CUBE_W(CUBE_W), .SHIFT(SHIFT)) u_comp (
        .clk(clk), .rst(rst), .cube_in(cube_s2), .lim_q(lim_s3)
    );

    sr_merge #(.PIX_W(PIX_W)) u_merge (
        .clk(clk), .rst(rst), .lim_in(lim_s3), .cen_in(cen_pipe[CEN_DLY-1]),
        .pix_q(out_pix)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_pipe <= '0;
            for (int i = 0; i < CEN_DLY; i++) cen_pipe[i] <= '0;
        end else begin
            vld_pipe <= {vld_pipe[LATENCY-2:0], in_valid};
            cen_pipe[0] <= ctr;
            for (int i = 1; i < CEN_DLY; i++) cen_pipe[i] <= cen_pipe[i-1];
        end
    end

    assign out_valid = vld_pipe[LATENCY-1];

    always_ff @(posedge clk) begin
        if (rst)                 warm_q <= '0;
        else if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
    end

    p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst || warm_q != 3'd5)
        out_valid == $past(in_valid, 5));
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pix == 0));
endmodule

// File: tb/tb_sr_sharpen_pipe.sv
`timescale 1ns/1ps
module tb_sr_sharpen_pipe;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [PW-1:0] ctr = '0, up = '0, dn = '0, lf = '0, rt = '0;
    logic out_valid;
    logic [PW-1:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit    v;
        int    pix;
        string tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    sr_sharpen_pipe dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ctr(ctr), .up(up), .dn(dn), .lf(lf), .rt(rt),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int model(int c, int n, int s, int e, int w);
        longint hp, cb, sh;
        int sum;
        hp = 4 * c - n - s - e - w;
        cb = hp * hp * hp;
        if (cb >= 0) sh = cb / 65536;
        else         sh = -((-cb + 65535) / 65536);
        if (sh > 255)  sh = 255;
        if (sh < -255) sh = -255;
        sum = c + int'(sh);
        if (sum < 0)   sum = 0;
        if (sum > 255) sum = 255;
        return sum;
    endfunction

    task automatic check(bit ok, string tag, int av, int ap, int ev, int ep);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got valid=%0d pix=%0d, expected valid=%0d pix=%0d",
                     tag, av, ap, ev, ep);
        end
    endtask

    task automatic step(bit v, int c, int n, int s, int e, int w, string tag);
        exp_t x;
        @(negedge clk);
        if (!rst && q.size() == 5) begin
            x = q.pop_front();
            check(out_valid == x.v && int'(out_pix) == x.pix, x.tag,
                  out_valid, out_pix, x.v, x.pix);
        end else if (q.size() == 5) begin
            void'(q.pop_front());
        end
        in_valid = v;
        ctr = PW'(c); up = PW'(n); dn = PW'(s); lf = PW'(e); rt = PW'(w);
        x.v = v;
        x.pix = rst ? 0 : model(c, n, s, e, w);
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state, with the valid input held high during reset
        rst = 1'b1;
        for (int i = 0; i < 6; i++) step(1'b0, 0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        in_valid = 1'b1; ctr = 8'd200;
        @(negedge clk);
        check(out_valid == 1'b0 && out_pix == 0, "R1", out_valid, out_pix, 0, 0);
        in_valid = 1'b0; ctr = '0;
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, 0, "R1");
        rst = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b0, 0, 0, 0, 0, 0, "R1");

        // R2: lone valid pulse, then gaps
        step(1'b1, 77, 77, 77, 77, 77, "R2");
        for (int i = 0; i < 7; i++) step(1'b0, 0, 0, 0, 0, 0, "R2");
        step(1'b1, 10, 0, 0, 0, 0, "R2");
        step(1'b0, 0, 0, 0, 0, 0, "R2");
        step(1'b1, 20, 0, 0, 0, 0, "R2");

        // R3: flat patches and single-neighbour patterns
        step(1'b1, 0, 0, 0, 0, 0, "R3");
        step(1'b1, 255, 255, 255, 255, 255, "R3");
        step(1'b1, 128, 128, 128, 128, 128, "R3");
        step(1'b1, 100, 60, 100, 100, 100, "R3");
        step(1'b1, 100, 100, 100, 100, 140, "R3");

        // R4: sign of the term moves output the right way
        step(1'b1, 120, 120, 120, 40, 40, "R4");
        step(1'b1, 120, 200, 200, 120, 120, "R4");

        // R5: rounding toward minus infinity at small terms
        step(1'b1, 100, 101, 100, 100, 100, "R5");
        step(1'b1, 100, 99, 100, 100, 100, "R5");
        step(1'b1, 100, 59, 100, 100, 100, "R5");
        step(1'b1, 200, 225, 225, 225, 225, "R5");
        step(1'b1, 200, 250, 250, 250, 250, "R5");

        // R6: compressed term driven into both clamps
        step(1'b1, 64, 0, 0, 0, 0, "R6");
        step(1'b1, 191, 255, 255, 255, 255, "R6");

        // R7: maximum centre stays positive
        step(1'b1, 255, 250, 250, 250, 250, "R7");
        step(1'b1, 255, 254, 255, 255, 255, "R7");

        // R8: both saturation rails and a pass-through
        step(1'b1, 200, 0, 0, 0, 0, "R8");
        step(1'b1, 30, 255, 255, 255, 255, "R8");
        step(1'b1, 30, 0, 0, 0, 0, "R8");

        // R9: unbroken stream of varied neighbourhoods
        for (int i = 0; i < 300; i++)
            step(1'b1, int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), int'($urandom_range(255)),
                 int'($urandom_range(255)), "R9");

        for (int i = 0; i < 8; i++) step(1'b0, 0, 0, 0, 0, 0, "R2");
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got running, expected finished");
        finish_run();
    end
endmodule